// File: doc/BRIEF.md
# Protection Region Base Register Bank

This block is the register pair that software uses to set where each memory-protection region starts. It holds a base address for each of a parameterised number of regions (16 by default), plus a current-region selector. Software can write the selector directly. It can also retarget the selector and program the new region's base in one write to the base register, by setting a marker bit in the write data. A write without the marker programs whichever region is already selected.

The base register is a window onto the selected region. The low alignment bits of a region's base always read as zero. How many bits that covers depends on the region's size code, which the block takes live from an input bus. The protection checker that consumes the bases and owns the size codes lies outside this block.

All accesses are single-cycle strobes on a small synchronous bus. A privilege flag qualifies every access. Read data and the error flag are registered and appear in the cycle after the strobe.

Top module: `prb_bank`

## Requirements
- R1: After synchronous reset the selector is 0, every stored base is 0, and `bus_rdata` and `bus_err` are 0.
- R2: The selector register sits at byte offset 0x08. A privileged write loads it from `bus_wdata[3:0]`. A read returns it in bits [3:0], with bits [31:4] zero.
- R3: A privileged write to the base register (offset 0x0C) with `bus_wdata[4]`=1 loads the selector from `bus_wdata[3:0]`. It stores `bus_wdata[31:5]` as the base of that newly named region.
- R4: A privileged write to the base register with `bus_wdata[4]`=0 leaves the selector unchanged and ignores `bus_wdata[3:0]`. It stores `bus_wdata[31:5]` as the base of the currently selected region.
- R5: A privileged read of the base register returns three fields: the selected region's masked base in bits [31:5], zero in bit 4, and the selector in bits [3:0].
- R6: The size code c of a region (5 bits per region in `size_codes`, region k at bits [5k+4:5k]) gives a size of 2^(c+1) bytes. Base read bits below position c+1 are zero. For c of 4 or less, all of bits [31:5] are shown.
- R7: A region with size code 31 (4 GB) reads back a base of zero in bits [31:5], whatever was written.
- R8: The mask comes from the live size code at read time. Stored bits hidden by a large size reappear once the code is lowered, without any rewrite.
- R9: An access with `bus_priv`=0 to offset 0x08 or 0x0C changes no state and returns 0 in `bus_rdata`. It raises `bus_err` for exactly the following cycle.
- R10: `bus_rdata` and `bus_err` are registered: they show the result of an access in the cycle after it and are 0 in any cycle not following a read. Accesses to other offsets read 0, are not stored and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| size_codes | input | NREG*SIZE_W (80) | Live size code for each region |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error, one cycle per denied access |

## Verification
The assertions assume that `bus_sel` is a single-cycle pulse per access and that all bus inputs are stable around the clock edge. They also assume that `size_codes` does not change during the cycle a base read is sampled. The bench drives every input on the falling edge and issues one strobe at a time, with an idle cycle between accesses. It changes size codes only between accesses, so every read sees one settled code and one settled selector.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int DATA_W  = 32;
  localparam int LOW_W   = 5;
  localparam int FIELD_W = DATA_W - LOW_W;
  localparam int SEL_BIT = 4;

  typedef struct packed {
    logic hit_sel;
    logic hit_base;
    logic wr_sel;
    logic wr_base;
    logic rd_ok;
    logic deny;
  } prb_acc_t;
endpackage

// File: rtl/prb_access_decode.sv
module prb_access_decode #(
  parameter int ADDR_W   = 8,
  parameter int SEL_OFS  = 8,
  parameter int BASE_OFS = 12
) (
  input  logic              sel,
  input  logic              we,
  input  logic              priv,
  input  logic [ADDR_W-1:0] addr,
  output prb_pkg::prb_acc_t acc
);
  logic hit_s, hit_b, mapped;

  assign hit_s  = (addr == ADDR_W'(SEL_OFS));
  assign hit_b  = (addr == ADDR_W'(BASE_OFS));
  assign mapped = hit_s | hit_b;

  always_comb begin
    acc.hit_sel  = hit_s;
    acc.hit_base = hit_b;
    acc.wr_sel   = sel & we & priv & hit_s;
    acc.wr_base  = sel & we & priv & hit_b;
    acc.rd_ok    = sel & ~we & priv & mapped;
    acc.deny     = sel & ~priv & mapped;
  end
endmodule

// File: rtl/prb_align_mask.sv
module prb_align_mask #(
  parameter int SIZE_W = 5
) (
  input  logic [SIZE_W-1:0]           code,
  output logic [prb_pkg::FIELD_W-1:0] keep
);
  import prb_pkg::*;

  for (genvar j = 0; j < FIELD_W; j++) begin : g_bit
    assign keep[j] = ((LOW_W + j) >= (int'(code) + 1));
  end
endmodule

// File: rtl/prb_region_store.sv
module prb_region_store #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [prb_pkg::FIELD_W-1:0] wfield,
  input  logic [IDX_W-1:0]            ridx,
  output logic [prb_pkg::FIELD_W-1:0] rfield
);
  import prb_pkg::*;

  logic [FIELD_W-1:0] slot [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[k] <= '0;
      else if (we && (widx == IDX_W'(k)))
        slot[k] <= wfield;
    end
  end

  assign rfield = slot[ridx];
endmodule

// File: rtl/prb_bank.sv
module prb_bank #(
  parameter int NREG     = 16,
  parameter int SIZE_W   = 5,
  parameter int ADDR_W   = 8,
  parameter int SEL_OFS  = 8,
  parameter int BASE_OFS = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_priv,
  input  logic [NREG*SIZE_W-1:0]   size_codes,
  output logic [31:0]              bus_rdata,
  output logic                     bus_err
);
  import prb_pkg::*;

  localparam int IDX_W = $clog2(NREG);

  prb_acc_t           acc;
  logic [IDX_W-1:0]   cur_q;
  logic [IDX_W-1:0]   tgt_idx;
  logic [FIELD_W-1:0] base_raw;
  logic [FIELD_W-1:0] keep;
  logic [SIZE_W-1:0]  cur_code;
  logic [DATA_W-1:0]  rd_base, rd_sel, rd_next;

  prb_access_decode #(
    .ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS), .BASE_OFS(BASE_OFS)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .priv(bus_priv), .addr(bus_addr), .acc(acc)
  );

  // Retarget on the marker bit, else keep the current region.
  assign tgt_idx = bus_wdata[SEL_BIT] ? bus_wdata[IDX_W-1:0] : cur_q;

  always_ff @(posedge clk) begin
    if (rst)
      cur_q <= '0;
    else if (acc.wr_sel || (acc.wr_base && bus_wdata[SEL_BIT]))
      cur_q <= bus_wdata[IDX_W-1:0];
  end

  prb_region_store #(.NREG(NREG), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .we(acc.wr_base), .widx(tgt_idx), .wfield(bus_wdata[DATA_W-1:LOW_W]),
    .ridx(cur_q), .rfield(base_raw)
  );

  assign cur_code = size_codes[cur_q*SIZE_W +: SIZE_W];

  prb_align_mask #(.SIZE_W(SIZE_W)) u_mask (.code(cur_code), .keep(keep));

  assign rd_base = {base_raw & keep, {LOW_W{1'b0}}} | DATA_W'(cur_q);
  assign rd_sel  = DATA_W'(cur_q);

  always_comb begin
    rd_next = '0;
    if (acc.rd_ok)
      rd_next = acc.hit_base ? rd_base : rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      bus_err   <= acc.deny;
    end
  end

  // R3: marker write retargets selector
  p_retarget_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_priv && bus_addr == ADDR_W'(BASE_OFS) && bus_wdata[SEL_BIT])
    |=> (cur_q == $past(bus_wdata[IDX_W-1:0])));

  // R4: unmarked base write keeps selector
  p_hold_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(BASE_OFS) && !bus_wdata[SEL_BIT])
    |=> $stable(cur_q));

  // R5: marker bit never reads back as one
  p_marker_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> (bus_rdata[SEL_BIT] == 1'b0));

  // R9: denied access raises error, returns zero, keeps state
  p_deny_err_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_priv && (bus_addr == ADDR_W'(SEL_OFS) || bus_addr == ADDR_W'(BASE_OFS)))
    |=> (bus_err && bus_rdata == '0 && $stable(cur_q)));

  // R10: idle cycles leave outputs quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (!bus_err && bus_rdata == '0));
endmodule

// File: tb/prb_bank_tb_top.sv
`timescale 1ns/1ps
module prb_bank_tb_top;
  localparam int NREG = 16;
  localparam int SW   = 5;

  logic clk = 0, rst = 1;
  logic sel = 0, we = 0, priv = 1;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [NREG*SW-1:0] codes;
  logic [31:0] rdata;
  logic err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prb_bank dut_i (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_priv(priv), .size_codes(codes),
    .bus_rdata(rdata), .bus_err(err)
  );

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input [7:0] a, input bit w, input [31:0] d, input bit p,
                     output [31:0] rd, output bit er);
    @(negedge clk);
    sel = 1; addr = a; we = w; wdata = d; priv = p;
    @(negedge clk);
    sel = 0; we = 0; priv = 1;
    rd = rdata; er = err;
  endtask

  function automatic [31:0] exp_base(input [31:0] raw, input int code, input int idx);
    logic [31:0] v = '0;
    for (int i = 5; i < 32; i++) if (i >= code + 1) v[i] = raw[i];
    return v | 32'(idx);
  endfunction

  function automatic void set_code(input int k, input int c);
    codes[k*SW +: SW] = SW'(c);
  endfunction

  task automatic t_reset();
    logic [31:0] r; bit e;
    chk("R1 rdata after reset", rdata, 0);
    chk("R1 err after reset", 32'(err), 0);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R1 selector after reset", r, 0);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R1 base after reset", r, 0);
  endtask

  task automatic t_sel_rw();
    logic [31:0] r; bit e;
    acc(8'h08, 1, 32'hFFFF_FFF9, 1, r, e);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R2 selector readback", r, 32'h9);
  endtask

  task automatic t_marker_write();
    logic [31:0] r; bit e;
    acc(8'h0C, 1, 32'hABCD_E010 | 32'h3, 1, r, e);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R3 selector retargeted", r, 32'h3);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R3 base stored in new region", r, exp_base(32'hABCD_E000, 4, 3));
    chk("R5 marker bit reads zero", 32'(r[4]), 0);
  endtask

  task automatic t_plain_write();
    logic [31:0] r; bit e;
    acc(8'h0C, 1, 32'h1234_5660 | 32'h7, 0, r, e);
    acc(8'h0C, 1, 32'h1111_1100 | 32'hA, 1, r, e);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R4 selector unchanged", r, 32'h3);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R4 base to current region", r, exp_base(32'h1111_1100, 4, 3));
    acc(8'h08, 1, 32'hA, 1, r, e);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R4 low bits not used as region", r, 32'hA);
  endtask

  task automatic t_align();
    logic [31:0] r; bit e;
    set_code(5, 15);
    acc(8'h0C, 1, 32'hFFFF_FFF0 | 32'h5, 1, r, e);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R6 64KB alignment", r, 32'hFFFF_0005);
    set_code(5, 4);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R8 hidden bits return", r, 32'hFFFF_FFE5);
    set_code(5, 9);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R6 1KB alignment", r, exp_base(32'hFFFF_FFE0, 9, 5));
    set_code(5, 31);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R7 full-size region base zero", r, 32'h5);
    set_code(5, 4);
  endtask

  task automatic t_unpriv();
    logic [31:0] r; bit e;
    acc(8'h08, 1, 32'h2, 0, r, e);
    chk("R9 denied write err", 32'(e), 1);
    chk("R9 denied write rdata", r, 0);
    @(negedge clk);
    chk("R9 err lasts one cycle", 32'(err), 0);
    acc(8'h0C, 0, 0, 0, r, e);
    chk("R9 denied read zero", r, 0);
    chk("R9 denied read err", 32'(e), 1);
    acc(8'h0C, 1, 32'hDEAD_BEE0, 0, r, e);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R9 selector untouched", r, 32'h5);
    acc(8'h0C, 0, 0, 1, r, e);
    chk("R9 base untouched", r, 32'hFFFF_FFE5);
  endtask

  task automatic t_timing();
    logic [31:0] r; bit e;
    acc(8'h10, 1, 32'hFFFF_FFFF, 1, r, e);
    chk("R10 unmapped write no err", 32'(e), 0);
    acc(8'h10, 0, 0, 1, r, e);
    chk("R10 unmapped read zero", r, 0);
    acc(8'h08, 0, 0, 1, r, e);
    chk("R10 selector unaffected by unmapped", r, 32'h5);
    @(negedge clk);
    chk("R10 rdata idle zero", rdata, 0);
    acc(8'h08, 1, 32'h1, 1, r, e);
    chk("R10 write returns zero data", r, 0);
  endtask

  initial begin
    codes = '0;
    for (int k = 0; k < NREG; k++) set_code(k, 4);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sel_rw();
    t_marker_write();
    t_plain_write();
    t_align();
    t_unpriv();
    t_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule